// File: doc/BRIEF.md
# Reset Source Status Recorder

This block remembers what caused the most recent system reset. Each possible cause arrives on its own request line from detection logic elsewhere in the chip: power-on, supply droop, low-leakage wakeup (qualified by a flag that says whether the reset pin was the wakeup source), external clock loss, PLL lock loss, watchdog expiry, external reset pin, JTAG, core lockup, software request, debug-port request, a flash-programming-port reset command and a stop-entry acknowledge timeout. Any cycle with at least one request line high is a reset event. On that clock edge the block replaces its stored cause with a fresh encoding of the lines that are high. Between events the stored cause does not change.

Software sees the cause as two read-only status bytes through a small register port. Requests use valid/ready. A request is accepted on a clock edge where `bus_req_valid` and `bus_req_ready` are both high. `bus_req_ready` is high when no response is pending, or when the pending response is being taken in the same cycle. Each accepted request produces exactly one response beat on `bus_rsp_valid`/`bus_rsp_data`. That beat holds steady until `bus_rsp_ready` is seen high at a clock edge. The block's own reset (`rst_n`) is treated as a power-on of the recorder.

Top module: `rst_cause_rec`

## Requirements
- R1: While `rst_n` is low and after it is released, with no reset event since, status byte 0 reads 0x82 and status byte 1 reads 0x00. At that point `bus_rsp_valid` is 0 and `bus_req_ready` is 1.
- R2: Status byte 0 (address 0) bit positions are: 0 wakeup, 1 low-voltage, 2 clock loss, 3 lock loss, 4 always 0, 5 watchdog, 6 external pin, 7 power-on.
- R3: Status byte 1 (address 1) bit positions are: 0 JTAG, 1 core lockup, 2 software, 3 debug-port request, 4 programming-port command, 5 stop-acknowledge timeout, 7:6 always 0.
- R4: An event with `req_por` high yields byte 0 = 0x82 and byte 1 = 0x00, whatever the other lines are.
- R5: A low-voltage request alone yields byte 0 = 0x02 and byte 1 = 0x00.
- R6: A wakeup request yields byte 0 bit 0 set. When `wake_by_pin` is also high, bit 6 is set too, so a lone wakeup reads 0x41 with the flag and 0x01 without it. `wake_by_pin` with no request line high is not an event and changes nothing.
- R7: Every event without `req_wake` clears byte 0 bit 0.
- R8: For an event without power-on, every request line that is high sets its own bit, and every other bit is cleared.
- R9: The status loads on the clock edge where the event is present. A read accepted on that same edge returns the previous value, and a read accepted on a later edge returns the new value. With no event, the status stays unchanged.
- R10: A write request (`bus_req_write` = 1) is accepted like a read, answered with data 0x00, and leaves both status bytes unchanged.
- R11: Reads of any address other than 0 or 1 return 0x00.
- R12: Each accepted request gives one response beat. While `bus_rsp_valid` is high and `bus_rsp_ready` is low, `bus_req_ready` is low and `bus_rsp_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, treated as power-on |
| req_por | input | 1 | Power-on reset request |
| req_lvd | input | 1 | Low-voltage reset request |
| req_wake | input | 1 | Low-leakage wakeup reset request |
| wake_by_pin | input | 1 | Qualifier: wakeup came from the reset pin |
| req_clk_loss | input | 1 | External clock loss reset request |
| req_lock_loss | input | 1 | PLL lock loss reset request |
| req_wdog | input | 1 | Watchdog reset request |
| req_ext_pin | input | 1 | External reset pin request |
| req_jtag | input | 1 | JTAG reset request |
| req_lockup | input | 1 | Core lockup reset request |
| req_sw | input | 1 | Software reset request |
| req_dbg | input | 1 | Debug-port reset request |
| req_prog | input | 1 | Programming-port reset command |
| req_stop_ack | input | 1 | Stop-entry acknowledge timeout |
| bus_req_valid | input | 1 | Register request valid |
| bus_req_ready | output | 1 | Register request ready |
| bus_req_write | input | 1 | Request is a write (ignored) |
| bus_req_addr | input | ADDR_W | Byte address |
| bus_rsp_valid | output | 1 | Response valid |
| bus_rsp_ready | input | 1 | Response ready |
| bus_rsp_data | output | 8 | Response byte |

## Verification
The main sweep pulses every combination of the fourteen request and qualifier lines, one at a time, and then reads both bytes. This separates power-on dominance, the OR of simultaneous causes, the pin qualifier's effect with and without wakeup, and the non-events that must leave the previous value alone. Directed patterns then line up an event with a read on the same edge to pin down the load cycle. Further patterns hold a response under back-pressure while a second request waits, write to the status bytes, read unmapped addresses, and re-apply reset partway through the run.

// File: rtl/rstrec_pkg.sv
package rstrec_pkg;

  localparam int STAT_W    = 8;
  localparam int NUM_BYTES = 2;

  // byte 0 bit positions
  localparam int B0_WAKE  = 0;
  localparam int B0_LVD   = 1;
  localparam int B0_CLKL  = 2;
  localparam int B0_LOCKL = 3;
  localparam int B0_WDOG  = 5;
  localparam int B0_PIN   = 6;
  localparam int B0_POR   = 7;

  // byte 1 bit positions
  localparam int B1_JTAG  = 0;
  localparam int B1_LOCKUP = 1;
  localparam int B1_SW    = 2;
  localparam int B1_DBG   = 3;
  localparam int B1_PROG  = 4;
  localparam int B1_STOP  = 5;

  localparam logic [STAT_W-1:0] POR_BYTE0 = STAT_W'((1 << B0_POR) | (1 << B0_LVD));
  localparam logic [STAT_W-1:0] POR_BYTE1 = '0;

  typedef struct packed {
    logic por;
    logic lvd;
    logic wake;
    logic wake_pin;
    logic clk_loss;
    logic lock_loss;
    logic wdog;
    logic ext_pin;
    logic jtag;
    logic lockup;
    logic sw;
    logic dbg;
    logic prog;
    logic stop_ack;
  } cause_t;

  typedef logic [NUM_BYTES-1:0][STAT_W-1:0] stat_bytes_t;

endpackage

// File: rtl/rstrec_encode.sv
module rstrec_encode
  import rstrec_pkg::*;
(
  input  cause_t            cause,
  output logic              evt,
  output logic [STAT_W-1:0] nxt0,
  output logic [STAT_W-1:0] nxt1
);

  logic [STAT_W-1:0] plain0;
  logic [STAT_W-1:0] plain1;

  // the pin qualifier alone is not a request
  assign evt = cause.por | cause.lvd | cause.wake | cause.clk_loss |
               cause.lock_loss | cause.wdog | cause.ext_pin | cause.jtag |
               cause.lockup | cause.sw | cause.dbg | cause.prog | cause.stop_ack;

  always_comb begin
    plain0 = '0;
    plain0[B0_WAKE]  = cause.wake;
    plain0[B0_LVD]   = cause.lvd;
    plain0[B0_CLKL]  = cause.clk_loss;
    plain0[B0_LOCKL] = cause.lock_loss;
    plain0[B0_WDOG]  = cause.wdog;
    plain0[B0_PIN]   = cause.ext_pin | (cause.wake & cause.wake_pin);

    plain1 = '0;
    plain1[B1_JTAG]   = cause.jtag;
    plain1[B1_LOCKUP] = cause.lockup;
    plain1[B1_SW]     = cause.sw;
    plain1[B1_DBG]    = cause.dbg;
    plain1[B1_PROG]   = cause.prog;
    plain1[B1_STOP]   = cause.stop_ack;
  end

  // power-on overrides every other cause
  assign nxt0 = cause.por ? POR_BYTE0 : plain0;
  assign nxt1 = cause.por ? POR_BYTE1 : plain1;

endmodule

// File: rtl/rstrec_capture.sv
module rstrec_capture
  import rstrec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [STAT_W-1:0] nxt0,
  input  logic [STAT_W-1:0] nxt1,
  output stat_bytes_t       stat
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat[0] <= POR_BYTE0;
      stat[1] <= POR_BYTE1;
    end else if (evt) begin
      stat[0] <= nxt0;
      stat[1] <= nxt1;
    end
  end

endmodule

// File: rtl/rstrec_rdport.sv
module rstrec_rdport
  import rstrec_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stat_bytes_t       stat,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [STAT_W-1:0] rsp_data
);

  logic [NUM_BYTES-1:0] hit;
  logic [STAT_W-1:0]    sel;
  logic                 accept;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BYTES; gi++) begin : g_dec
      assign hit[gi] = (req_addr == ADDR_W'(gi));
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (hit[i]) sel = stat[i];
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= req_write ? '0 : sel;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/rst_cause_rec.sv
module rst_cause_rec
  import rstrec_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_por,
  input  logic              req_lvd,
  input  logic              req_wake,
  input  logic              wake_by_pin,
  input  logic              req_clk_loss,
  input  logic              req_lock_loss,
  input  logic              req_wdog,
  input  logic              req_ext_pin,
  input  logic              req_jtag,
  input  logic              req_lockup,
  input  logic              req_sw,
  input  logic              req_dbg,
  input  logic              req_prog,
  input  logic              req_stop_ack,
  input  logic              bus_req_valid,
  output logic              bus_req_ready,
  input  logic              bus_req_write,
  input  logic [ADDR_W-1:0] bus_req_addr,
  output logic              bus_rsp_valid,
  input  logic              bus_rsp_ready,
  output logic [STAT_W-1:0] bus_rsp_data
);

  cause_t            cause;
  logic              evt;
  logic [STAT_W-1:0] nxt0;
  logic [STAT_W-1:0] nxt1;
  stat_bytes_t       stat;

  assign cause = '{por:       req_por,
                   lvd:       req_lvd,
                   wake:      req_wake,
                   wake_pin:  wake_by_pin,
                   clk_loss:  req_clk_loss,
                   lock_loss: req_lock_loss,
                   wdog:      req_wdog,
                   ext_pin:   req_ext_pin,
                   jtag:      req_jtag,
                   lockup:    req_lockup,
                   sw:        req_sw,
                   dbg:       req_dbg,
                   prog:      req_prog,
                   stop_ack:  req_stop_ack};

  rstrec_encode u_enc (
    .cause (cause),
    .evt   (evt),
    .nxt0  (nxt0),
    .nxt1  (nxt1)
  );

  rstrec_capture u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .nxt0  (nxt0),
    .nxt1  (nxt1),
    .stat  (stat)
  );

  rstrec_rdport #(.ADDR_W(ADDR_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat      (stat),
    .req_valid (bus_req_valid),
    .req_ready (bus_req_ready),
    .req_write (bus_req_write),
    .req_addr  (bus_req_addr),
    .rsp_valid (bus_rsp_valid),
    .rsp_ready (bus_rsp_ready),
    .rsp_data  (bus_rsp_data)
  );

endmodule

// File: rtl/rstrec_chk.sv
module rstrec_chk
  import rstrec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_por,
  input logic              req_wake,
  input logic              any_req,
  input logic [STAT_W-1:0] s0,
  input logic [STAT_W-1:0] s1,
  input logic              acc_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [STAT_W-1:0] rsp_data
);

  // R4
  por_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_por |=> (s0 == 8'h82 && s1 == 8'h00));

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> ($stable(s0) && $stable(s1)));

  // R7
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && !req_wake) |=> !s0[0]);

  // R6
  wake_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wake && !req_por) |=> s0[0]);

  // R10
  write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_write |=> (rsp_valid && rsp_data == 8'h00));

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

endmodule

bind rst_cause_rec rstrec_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_por   (req_por),
  .req_wake  (req_wake),
  .any_req   (req_por | req_lvd | req_wake | req_clk_loss | req_lock_loss |
              req_wdog | req_ext_pin | req_jtag | req_lockup | req_sw |
              req_dbg | req_prog | req_stop_ack),
  .s0        (stat[0]),
  .s1        (stat[1]),
  .acc_write (bus_req_valid & bus_req_ready & bus_req_write),
  .rsp_valid (bus_rsp_valid),
  .rsp_ready (bus_rsp_ready),
  .rsp_data  (bus_rsp_data)
);

// File: tb/rst_cause_rec_test.sv
module rst_cause_rec_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [13:0] lines = '0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [2:0] req_addr = '0;
  logic rsp_ready = 1'b0;
  logic req_ready;
  logic rsp_valid;
  logic [7:0] rsp_data;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [7:0] exp0;
  logic [7:0] exp1;
  logic [7:0] got;

  always #2 clk = ~clk;

  rst_cause_rec uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_por       (lines[0]),
    .req_lvd       (lines[1]),
    .req_wake      (lines[2]),
    .wake_by_pin   (lines[3]),
    .req_clk_loss  (lines[4]),
    .req_lock_loss (lines[5]),
    .req_wdog      (lines[6]),
    .req_ext_pin   (lines[7]),
    .req_jtag      (lines[8]),
    .req_lockup    (lines[9]),
    .req_sw        (lines[10]),
    .req_dbg       (lines[11]),
    .req_prog      (lines[12]),
    .req_stop_ack  (lines[13]),
    .bus_req_valid (req_valid),
    .bus_req_ready (req_ready),
    .bus_req_write (req_write),
    .bus_req_addr  (req_addr),
    .bus_rsp_valid (rsp_valid),
    .bus_rsp_ready (rsp_ready),
    .bus_rsp_data  (rsp_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    total = total + 1;
    if (act !== expv) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, expv);
    end
  endtask

  // expected status from a line vector: bit n of lines = weight of its field
  task automatic model(input logic [13:0] v);
    if (v[0]) begin
      exp0 = 8'd128 + 8'd2;
      exp1 = 8'd0;
    end else if ((v & 14'h3FF7) != 0) begin
      exp0 = 8'(v[2]) * 1 + 8'(v[1]) * 2 + 8'(v[4]) * 4 + 8'(v[5]) * 8 +
             8'(v[6]) * 32 + 8'(v[7] | (v[2] & v[3])) * 64;
      exp1 = 8'(v[8]) * 1 + 8'(v[9]) * 2 + 8'(v[10]) * 4 + 8'(v[11]) * 8 +
             8'(v[12]) * 16 + 8'(v[13]) * 32;
    end
  endtask

  task automatic pulse(input logic [13:0] v);
    @(negedge clk) lines = v;
    @(negedge clk) lines = '0;
  endtask

  task automatic bus_op(input logic wr, input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R12 rsp_valid after accept", 8'(rsp_valid), 8'd1);
    d = rsp_data;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R12 rsp_valid after take", 8'(rsp_valid), 8'd0);
  endtask

  initial begin
    exp0 = 8'h82; exp1 = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 8'(req_ready), 8'd1);
    check("R1 rsp_valid in reset", 8'(rsp_valid), 8'd0);
    rst_n = 1'b1;
    bus_op(1'b0, 3'd0, got); check("R1 byte0 after reset", got, 8'h82);
    bus_op(1'b0, 3'd1, got); check("R1 byte1 after reset", got, 8'h00);

    // R5 and R6 lone cases
    pulse(14'h0002); model(14'h0002);
    bus_op(1'b0, 3'd0, got); check("R5 lvd alone", got, 8'h02);
    pulse(14'h000C); model(14'h000C);
    bus_op(1'b0, 3'd0, got); check("R6 wake by pin", got, 8'h41);
    pulse(14'h0004); model(14'h0004);
    bus_op(1'b0, 3'd0, got); check("R6 wake other", got, 8'h01);

    // sweep every line combination (R2 R3 R4 R6 R7 R8 R9)
    for (int v = 0; v < 16384; v++) begin
      pulse(14'(v));
      model(14'(v));
      bus_op(1'b0, 3'd0, got); check("R2 R4 R7 R8 byte0 sweep", got, exp0);
      bus_op(1'b0, 3'd1, got); check("R3 R4 R8 byte1 sweep", got, exp1);
    end

    // R9: event and read on the same edge returns the old value
    pulse(14'h0100); model(14'h0100);
    @(negedge clk);
    lines = 14'h0040; req_valid = 1'b1; req_addr = 3'd0; rsp_ready = 1'b0;
    @(negedge clk);
    lines = '0; req_valid = 1'b0;
    check("R9 same-edge read old", rsp_data, exp0);
    rsp_ready = 1'b1;
    @(negedge clk) rsp_ready = 1'b0;
    model(14'h0040);
    bus_op(1'b0, 3'd0, got); check("R9 next read new", got, 8'h20);
    repeat (5) @(negedge clk);
    bus_op(1'b0, 3'd0, got); check("R9 held byte0", got, 8'h20);

    // R10 writes ignored
    bus_op(1'b1, 3'd0, got); check("R10 write response", got, 8'h00);
    bus_op(1'b1, 3'd1, got); check("R10 write response b1", got, 8'h00);
    bus_op(1'b0, 3'd0, got); check("R10 byte0 unchanged", got, 8'h20);

    // R11 unmapped addresses
    bus_op(1'b0, 3'd2, got); check("R11 addr2", got, 8'h00);
    bus_op(1'b0, 3'd7, got); check("R11 addr7", got, 8'h00);

    // R12 back-pressure with a second request waiting
    pulse(14'h2200); model(14'h2200);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 3'd1; rsp_ready = 1'b0;
    @(negedge clk);
    req_addr = 3'd0;
    check("R12 ready low under stall", 8'(req_ready), 8'd0);
    check("R12 first data", rsp_data, exp1);
    lines = 14'h0010;
    @(negedge clk);
    lines = '0;
    check("R12 data held", rsp_data, 8'h22);
    check("R12 valid held", 8'(rsp_valid), 8'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 second data", rsp_data, 8'h04);
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R12 drained", 8'(rsp_valid), 8'd0);

    // R1 reset mid-run
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    bus_op(1'b0, 3'd0, got); check("R1 byte0 after re-reset", got, 8'h82);
    bus_op(1'b0, 3'd1, got); check("R1 byte1 after re-reset", got, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule